// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital side of a general-purpose 8-bit successive-approximation converter. It decides when a conversion may begin and steps a trial code through a binary search against an external comparator. It streams each decided bit on a serial data/clock pair and keeps the final code in a result register that the host can read. The analog comparator, the trial DAC and the serial host transport are outside the block. Host registers are reached through a plain parallel write/read port.

The block has two configuration sources. In pin mode, the analog input choice and the input range come from dedicated pins, and the conversion clock divide is fixed by a parameter. In register mode, all three come from a mode register that the host writes. A conversion is requested only when the start pin and an arm bit in the control register are both high. It launches only on a fresh low-to-high change of that combined condition. While a conversion runs, the block shuts out start requests, register writes and pin changes. The previous result stays visible until the new code is complete.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the mode register (address 1) reads 0x90 and the result register (address 2) reads 0x00. At the same time busy, selErr and serClk are 0, and muxSel is 3'b001.
- R2: A conversion starts only when the AND of startPin and control bit 7 goes from 0 to 1. busy is 1 in the cycle after that edge. startPin alone, or bit 7 alone, starts nothing.
- R3: A request held high never starts a second conversion. The request must return low, and its next rising edge starts a new one.
- R4: While busy is 1, register writes are dropped, and pinSel, pinRange and startPin changes have no effect on muxSel, rangeSel or the register contents. A request edge seen during busy is not remembered.
- R5: The result register keeps its old value through the conversion and takes the new code at the final decision. busy stays 1 for exactly 8*P+1 cycles, where P is the conversion clock period in system cycles.
- R6: The search is MSB-first and starts from trial code 0x80. cmpIn=1 means the input is at or above dacCode, and the bit under trial is then kept. The result is the largest code the comparator accepts.
- R7: After each of the 8 decisions, serClk is high for one system cycle, with serData equal to the decided bit. The bits come MSB first.
- R8: Control bit 0 selects the source. When it is 1, mode bits [1:0] give the input select, bits [4:2] the range and bits [7:5] the divide code. When it is 0, pinSel, pinRange and the BASIC_DIV parameter are used. These settings are taken while idle.
- R9: Input select code 00 drives muxSel=3'b001, code 10 drives 3'b010 and code 11 drives 3'b100. muxSel always has exactly one bit set.
- R10: Input select code 01 is reserved. It leaves muxSel at its last valid value and sets selErr, which stays set until reset.
- R11: The conversion clock period P is 2^(divide code + 1) system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 control, 1 mode, 2 result |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for regAddr |
| startPin | input | 1 | External conversion enable |
| pinSel | input | 2 | Input select used in pin mode |
| pinRange | input | 3 | Input range used in pin mode |
| cmpIn | input | 1 | Comparator: 1 when the input is at or above dacCode |
| dacCode | output | 8 | Trial code for the DAC |
| muxSel | output | 3 | One-hot analog input select |
| rangeSel | output | 3 | Input range code |
| serData | output | 1 | Serial result bit |
| serClk | output | 1 | Serial bit strobe |
| busy | output | 1 | Conversion in progress |
| selErr | output | 1 | Sticky reserved-select flag |

## Verification
A wrong bit-position state shows up at the ports as a bad pulse count on serClk, or as a busy window that differs from 8*P+1 cycles. Both are visible by the end of the conversion. A wrong trial-code update gives serial bits and a stored code that differ from the bench's comparator model, from the first wrong decision onward. A settings latch that updates while busy, or a lost edge-detect state, moves muxSel, changes a register readback or causes an extra conversion within a few cycles of the stimulus.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CONV = 2'd1,
    SEQ_DONE = 2'd2
  } seqState_t;

  typedef struct packed {
    logic start;  // launch a conversion this cycle
    logic tick;   // conversion-clock decision point
    logic last;   // decision of the final bit
    logic busy;   // conversion in progress (registered state)
  } seqStrb_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_MODE   = 2'd1;
  localparam logic [1:0] ADDR_RESULT = 2'd2;

  localparam logic [1:0] SEL_RESERVED = 2'b01;

endpackage

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SAR_W = 8,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigReq,
  input  logic [DIV_W-1:0] divCode,
  output seqStrb_t         strb
);

  localparam int CNT_W = 1 << DIV_W;
  localparam int IDX_W = $clog2(SAR_W);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(SAR_W - 1);

  seqState_t        state;
  logic             trigPrev;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;
  logic [CNT_W:0]   periodM1;
  logic [DIV_W:0]   shamt;
  logic             periodEnd;

  // Period of the conversion clock minus one: 2^(div+1) - 1
  always_comb begin
    shamt     = {1'b0, divCode} + (DIV_W+1)'(1);
    periodM1  = ((CNT_W+1)'(1) << shamt) - (CNT_W+1)'(1);
    periodEnd = ({1'b0, cnt} == periodM1);
  end

  always_comb begin
    strb.busy  = (state != SEQ_IDLE);
    strb.start = (state == SEQ_IDLE) && trigReq && !trigPrev;
    strb.tick  = (state == SEQ_CONV) && periodEnd;
    strb.last  = strb.tick && (bitIdx == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      trigPrev <= 1'b0;
      cnt      <= '0;
      bitIdx   <= '0;
    end else begin
      trigPrev <= trigReq;
      unique case (state)
        SEQ_IDLE: begin
          if (strb.start) begin
            state  <= SEQ_CONV;
            cnt    <= '0;
            bitIdx <= IDX_TOP;
          end
        end
        SEQ_CONV: begin
          if (periodEnd) begin
            cnt <= '0;
            if (bitIdx == '0) state <= SEQ_DONE;
            else              bitIdx <= bitIdx - IDX_W'(1);
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        SEQ_DONE: state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_seq_dpath.sv
`timescale 1ns/1ps
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int          SAR_W     = 8,
  parameter int          DIV_W     = 3,
  parameter int          RNG_W     = 3,
  parameter int          BASIC_DIV = 1,
  parameter logic [7:0]  MODE_RST  = 8'h90
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [SAR_W-1:0] regWrData,
  output logic [SAR_W-1:0] regRdData,
  input  logic             startPin,
  input  logic [1:0]       pinSel,
  input  logic [RNG_W-1:0] pinRange,
  input  logic             cmpIn,
  input  seqStrb_t         strb,
  output logic             trigReq,
  output logic [DIV_W-1:0] divCode,
  output logic [SAR_W-1:0] dacCode,
  output logic [SAR_W-1:0] resultQ,
  output logic [2:0]       muxSel,
  output logic [RNG_W-1:0] rangeSel,
  output logic             serData,
  output logic             serClk,
  output logic             selErr
);

  localparam int RNG_LO = 2;
  localparam int DIV_LO = SAR_W - DIV_W;
  localparam logic [SAR_W-1:0] MSB_MASK = SAR_W'(1) << (SAR_W - 1);

  logic [SAR_W-1:0] ctrlReg, modeReg, dacQ, maskQ, decided;
  logic             enhMode;
  logic [1:0]       effSel;
  logic [RNG_W-1:0] effRange;
  logic [DIV_W-1:0] effDiv;
  logic [2:0]       selOneHot;
  logic             selValid;

  always_comb begin
    enhMode  = ctrlReg[0];
    trigReq  = startPin & ctrlReg[SAR_W-1];
    effSel   = enhMode ? modeReg[1:0] : pinSel;
    effRange = enhMode ? modeReg[RNG_LO +: RNG_W] : pinRange;
    effDiv   = enhMode ? modeReg[DIV_LO +: DIV_W] : DIV_W'(BASIC_DIV);
    selValid = (effSel != SEL_RESERVED);
    unique case (effSel)
      2'b00:   selOneHot = 3'b001;
      2'b10:   selOneHot = 3'b010;
      2'b11:   selOneHot = 3'b100;
      default: selOneHot = 3'b000;
    endcase
    decided = cmpIn ? dacQ : (dacQ & ~maskQ);
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:   regRdData = ctrlReg;
      ADDR_MODE:   regRdData = modeReg;
      ADDR_RESULT: regRdData = resultQ;
      default:     regRdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      modeReg  <= SAR_W'(MODE_RST);
      resultQ  <= '0;
      dacQ     <= '0;
      maskQ    <= '0;
      muxSel   <= 3'b001;
      rangeSel <= MODE_RST[RNG_LO +: RNG_W];
      divCode  <= MODE_RST[DIV_LO +: DIV_W];
      serData  <= 1'b0;
      serClk   <= 1'b0;
      selErr   <= 1'b0;
    end else begin
      // Host writes and settings capture are locked out while busy
      if (regWrEn && !strb.busy) begin
        if (regAddr == ADDR_CTRL) ctrlReg <= regWrData;
        if (regAddr == ADDR_MODE) modeReg <= regWrData;
      end
      if (!strb.busy) begin
        rangeSel <= effRange;
        divCode  <= effDiv;
        if (selValid) muxSel <= selOneHot;
        else          selErr <= 1'b1;
      end
      serClk <= strb.tick;
      if (strb.tick) serData <= cmpIn;
      if (strb.start) begin
        dacQ  <= MSB_MASK;
        maskQ <= MSB_MASK;
      end else if (strb.tick) begin
        dacQ  <= decided | (maskQ >> 1);
        maskQ <= maskQ >> 1;
        if (strb.last) resultQ <= decided;
      end
    end
  end

  assign dacCode = dacQ;

endmodule

// File: rtl/adc_seq_top.sv
`timescale 1ns/1ps
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int         SAR_W     = 8,
  parameter int         DIV_W     = 3,
  parameter int         RNG_W     = 3,
  parameter int         BASIC_DIV = 1,
  parameter logic [7:0] MODE_RST  = 8'h90
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [SAR_W-1:0] regWrData,
  output logic [SAR_W-1:0] regRdData,
  input  logic             startPin,
  input  logic [1:0]       pinSel,
  input  logic [RNG_W-1:0] pinRange,
  input  logic             cmpIn,
  output logic [SAR_W-1:0] dacCode,
  output logic [2:0]       muxSel,
  output logic [RNG_W-1:0] rangeSel,
  output logic             serData,
  output logic             serClk,
  output logic             busy,
  output logic             selErr
);

  seqStrb_t         strb;
  logic             trigReq;
  logic [DIV_W-1:0] divCode;
  logic [SAR_W-1:0] resultQ;

  adc_seq_ctrl #(.SAR_W(SAR_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigReq(trigReq), .divCode(divCode), .strb(strb)
  );

  adc_seq_dpath #(
    .SAR_W(SAR_W), .DIV_W(DIV_W), .RNG_W(RNG_W),
    .BASIC_DIV(BASIC_DIV), .MODE_RST(MODE_RST)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .startPin(startPin),
    .pinSel(pinSel), .pinRange(pinRange), .cmpIn(cmpIn), .strb(strb),
    .trigReq(trigReq), .divCode(divCode), .dacCode(dacCode),
    .resultQ(resultQ), .muxSel(muxSel), .rangeSel(rangeSel),
    .serData(serData), .serClk(serClk), .selErr(selErr)
  );

  assign busy = strb.busy;

endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk #(
  parameter int SAR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             trigReq,
  input logic             busy,
  input logic             lastStb,
  input logic [SAR_W-1:0] resultQ,
  input logic [2:0]       muxSel,
  input logic             selErr,
  input logic             serClk
);

  a_r2_fresh_edge_starts: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && trigReq && !$past(trigReq)) |=> busy);

  a_r3_held_request_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && trigReq && $past(trigReq)) |=> !busy);

  a_r4_mux_frozen_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(muxSel));

  a_r5_result_holds: assert property (@(posedge clk) disable iff (!rstN)
    !lastStb |=> $stable(resultQ));

  a_r5_busy_after_update: assert property (@(posedge clk) disable iff (!rstN)
    lastStb |=> busy);

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    serClk |=> !serClk);

  a_r9_mux_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(muxSel) == 1);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    selErr |=> selErr);

endmodule

bind adc_seq_top adc_seq_chk #(.SAR_W(SAR_W)) u_chk (
  .clk(clk), .rstN(rstN), .trigReq(trigReq), .busy(busy),
  .lastStb(strb.last), .resultQ(resultQ), .muxSel(muxSel),
  .selErr(selErr), .serClk(serClk)
);

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int BASIC_P    = 4;   // 2^(BASIC_DIV+1) with BASIC_DIV = 1
  localparam int NVEC       = 6;

  // {enh, sel[1:0], div[2:0], rng[2:0], ana[7:0], expMux[2:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 2'b00, 3'd0, 3'd2, 8'hA5, 3'b001},
    {1'b0, 2'b10, 3'd0, 3'd5, 8'h00, 3'b010},
    {1'b1, 2'b11, 3'd0, 3'd1, 8'hFF, 3'b100},
    {1'b1, 2'b00, 3'd2, 3'd7, 8'h80, 3'b001},
    {1'b1, 2'b10, 3'd1, 3'd0, 8'h7F, 3'b010},
    {1'b0, 2'b11, 3'd0, 3'd3, 8'h01, 3'b100}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       startPin = 1'b0;
  logic [1:0] pinSel = 2'b00;
  logic [2:0] pinRange = 3'd0;
  logic       cmpIn;
  logic [7:0] dacCode;
  logic [2:0] muxSel;
  logic [2:0] rangeSel;
  logic       serData, serClk, busy, selErr;

  logic [7:0] anaVal = 8'h00;
  int         checks = 0;
  int         fails = 0;
  int         serCnt = 0;
  logic [7:0] serShift = 8'h00;
  bit         finished = 1'b0;

  assign cmpIn = (anaVal >= dacCode);

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_top u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .startPin(startPin),
    .pinSel(pinSel), .pinRange(pinRange), .cmpIn(cmpIn), .dacCode(dacCode),
    .muxSel(muxSel), .rangeSel(rangeSel), .serData(serData),
    .serClk(serClk), .busy(busy), .selErr(selErr)
  );

  always @(negedge clk) begin
    if (serClk) begin
      serShift <= {serShift[6:0], serData};
      serCnt   <= serCnt + 1;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic runConv(input int expP, input logic [7:0] ana,
                         input logic [7:0] oldRes);
    int busyLen;
    logic [7:0] rd;
    anaVal = ana;
    @(negedge clk);
    serCnt = 0;
    serShift = 8'h00;
    startPin = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R2 busy after request edge", busy, 1);
    rdReg(2'd2, rd);
    check(rd == oldRes, "R5 old result kept during conversion", rd, oldRes);
    busyLen = 1;
    while (busy) begin
      @(negedge clk);
      if (busy) busyLen++;
    end
    check(busyLen == 8*expP + 1, "R11 busy length 8*P+1", busyLen, 8*expP + 1);
    check(serCnt == 8, "R7 serial strobe count", serCnt, 8);
    check(serShift == ana, "R7 serial bits MSB first", serShift, ana);
    rdReg(2'd2, rd);
    check(rd == ana, "R6 converted code", rd, ana);
  endtask

  initial begin
    logic [7:0] rd;
    logic [7:0] prevRes;
    logic [7:0] modeShadow;
    int expP;

    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(2'd0, rd); check(rd == 8'h00, "R1 control reset", rd, 8'h00);
    rdReg(2'd1, rd); check(rd == 8'h90, "R1 mode reset", rd, 8'h90);
    rdReg(2'd2, rd); check(rd == 8'h00, "R1 result reset", rd, 8'h00);
    check(busy == 1'b0, "R1 busy reset", busy, 0);
    check(selErr == 1'b0, "R1 selErr reset", selErr, 0);
    check(serClk == 1'b0, "R1 serClk reset", serClk, 0);
    check(muxSel == 3'b001, "R1 muxSel reset", muxSel, 3'b001);

    // R2: pin alone, then arm bit alone, start nothing
    startPin = 1'b1;
    waitCycles(5);
    check(busy == 1'b0, "R2 pin alone no start", busy, 0);
    startPin = 1'b0;
    wrReg(2'd0, 8'h80);
    waitCycles(5);
    check(busy == 1'b0, "R2 arm bit alone no start", busy, 0);

    // Vector table: modes, selects, divides, codes
    prevRes = 8'h00;
    for (int v = 0; v < NVEC; v++) begin
      logic       enh;
      logic [1:0] sel;
      logic [2:0] dv, rg, em;
      logic [7:0] an;
      {enh, sel, dv, rg, an, em} = VEC[v];
      if (enh) begin
        pinSel = 2'b11; pinRange = 3'd6;
        wrReg(2'd1, {dv, rg, sel});
        wrReg(2'd0, 8'h81);
        expP = 2 << dv;
      end else begin
        pinSel = sel; pinRange = rg;
        wrReg(2'd1, {3'd6, 3'd0, 2'b11});
        wrReg(2'd0, 8'h80);
        expP = BASIC_P;
      end
      @(negedge clk);
      check(muxSel == em, "R9 select decode", muxSel, em);
      check(rangeSel == rg, "R8 range source", rangeSel, rg);
      runConv(expP, an, prevRes);
      prevRes = an;
      startPin = 1'b0;
      @(negedge clk);
    end
    check(selErr == 1'b0, "R10 no error with valid codes", selErr, 0);

    // R3: held request does not retrigger; low then high does
    wrReg(2'd0, 8'h80);
    pinSel = 2'b00; pinRange = 3'd1;
    runConv(BASIC_P, 8'h3C, prevRes);
    prevRes = 8'h3C;
    waitCycles(20);
    check(busy == 1'b0, "R3 held request no retrigger", busy, 0);
    startPin = 1'b0;
    @(negedge clk);
    runConv(BASIC_P, 8'hC3, prevRes);
    prevRes = 8'hC3;
    startPin = 1'b0;

    // R4: lockout during a conversion
    rdReg(2'd1, modeShadow);
    anaVal = 8'h5A;
    @(negedge clk);
    startPin = 1'b1;
    waitCycles(3);
    check(busy == 1'b1, "R4 conversion running", busy, 1);
    wrReg(2'd1, 8'h55);
    rdReg(2'd1, rd);
    check(rd == modeShadow, "R4 mode write dropped while busy", rd, modeShadow);
    wrReg(2'd0, 8'h01);
    rdReg(2'd0, rd);
    check(rd == 8'h80, "R4 control write dropped while busy", rd, 8'h80);
    pinSel = 2'b10; pinRange = 3'd6;
    @(negedge clk);
    check(muxSel == 3'b001, "R4 muxSel frozen while busy", muxSel, 3'b001);
    check(rangeSel == 3'd1, "R4 rangeSel frozen while busy", rangeSel, 1);
    startPin = 1'b0;
    @(negedge clk);
    startPin = 1'b1;
    while (busy) @(negedge clk);
    waitCycles(3);
    check(busy == 1'b0, "R4 edge during busy not remembered", busy, 0);
    rdReg(2'd2, rd);
    check(rd == 8'h5A, "R6 code after lockout test", rd, 8'h5A);
    check(muxSel == 3'b010, "R8 pins taken again when idle", muxSel, 3'b010);
    check(rangeSel == 3'd6, "R8 range taken again when idle", rangeSel, 6);
    startPin = 1'b0;

    // R10: reserved select code
    pinSel = 2'b01;
    waitCycles(2);
    check(muxSel == 3'b010, "R10 muxSel holds on reserved code", muxSel, 3'b010);
    check(selErr == 1'b1, "R10 selErr set on reserved code", selErr, 1);
    pinSel = 2'b00;
    waitCycles(2);
    check(muxSel == 3'b001, "R9 code 00 after reserved", muxSel, 3'b001);
    check(selErr == 1'b1, "R10 selErr sticky", selErr, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule